// File: doc/BRIEF.md
# Paged Memory Mapping Unit

This block sits between a 20-bit CPU address bus, a four-channel DMA engine and a 24-bit physical memory. It holds a small RAM of 16-bit bank registers that software loads over an I/O port. Each 16 KB window of the CPU's 1 MB space is redirected to any 16 KB bank of a 16 MB physical space. Each 16 KB quarter of every DMA channel's 64 KB space is redirected the same way.

Both translations are combinational lookups into the register RAM. A register write is seen by translation from the next cycle.

Spare DMA registers also serve as a warm-restart marker. When every DMA channel holds a fixed two-word signature in its upper two quarters, the block raises a single flag so boot code can skip its memory test.

Top module: `pagemap_top`

## Requirements
- R1: After reset, the CPU register for window n holds n, so the low 1 MB maps to itself. All DMA registers hold zero and `warm_boot` is 0.
- R2: `cpu_paddr` = {bank[9:0], cpu_addr[13:0]}. Here bank is the register at I/O port 2*n and n = cpu_addr[19:14].
- R3: `dma_paddr` = {bank[9:0], dma_addr[13:0]}. Here bank is the register at port 0x0080 + 8*c + 2*q, with c = `dma_chan` and q = dma_addr[15:14].
- R4: A write with `io_wr` high in one cycle changes translation from the following cycle. A translation of the same register in the write cycle uses the old value.
- R5: All 16 bits of a written word are stored and read back. Bits 10 to 15 have no effect on either translation.
- R6: `warm_boot` is 1 exactly when every channel holds 0x00AD in quarter 2 (port 0x0084 + 8*c) and 0x00EC in quarter 3 (port 0x0086 + 8*c). Writes to CPU registers never change it.
- R7: I/O address bit 0 is ignored, so port 0x0011 selects the register at 0x0010. Writes to any port above 0x009F change no register.
- R8: `io_rdata` returns the selected register while `io_rd` is high and the port is at or below 0x009F. Otherwise it is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 16 | I/O port address |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 16 | Write data |
| io_rdata | output | 16 | Read data |
| cpu_addr | input | 20 | CPU logical address |
| cpu_paddr | output | 24 | CPU physical address |
| dma_chan | input | 2 | DMA channel number |
| dma_addr | input | 16 | DMA logical address |
| dma_paddr | output | 24 | DMA physical address |
| warm_boot | output | 1 | All channels hold the warm-restart signature |

## Verification
Translation is combinational, so a corrupted or misplaced register value shows on `cpu_paddr` or `dma_paddr` as soon as that window is addressed. The same value appears on `io_rdata` as soon as its port is read. A decode fault shows up as a physical address in a window that was never written, one cycle after the stray write. A faulty signature compare shows as `warm_boot` changing in the cycle after the writes that complete or break the signature.

// File: rtl/pagemap_pkg.sv
package pagemap_pkg;
    localparam int WORD_W    = 16;
    localparam int BANK_W    = 10;
    localparam int OFS_W     = 14;
    localparam int CPU_AW    = 20;
    localparam int DMA_AW    = 16;
    localparam int IO_AW     = 16;
    localparam int DMA_CHANS = 4;
    localparam int CHAN_W    = $clog2(DMA_CHANS);
    localparam int CPU_SEL_W = CPU_AW - OFS_W;
    localparam int QTR_W     = DMA_AW - OFS_W;
    localparam int CPU_WINS  = 1 << CPU_SEL_W;
    localparam int DMA_QTRS  = 1 << QTR_W;
    localparam int DMA_REGS  = DMA_CHANS * DMA_QTRS;
    localparam int DMA_SEL_W = CHAN_W + QTR_W;
    localparam int NREGS     = CPU_WINS + DMA_REGS;
    localparam int IDX_W     = $clog2(NREGS);
    localparam int PA_W      = BANK_W + OFS_W;

    localparam logic [WORD_W-1:0] SIG_Q2 = 16'h00AD;
    localparam logic [WORD_W-1:0] SIG_Q3 = 16'h00EC;

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
    } regsel_t;

    // Word ports are even; the register index is the port halved.
    function automatic regsel_t decode_port(input logic [IO_AW-1:0] a);
        regsel_t r;
        logic [IO_AW-2:0] p;
        p     = a[IO_AW-1:1];
        r.hit = (int'(p) < NREGS);
        r.idx = IDX_W'(p);
        return r;
    endfunction
endpackage

// File: rtl/pagemap_regs.sv
module pagemap_regs
    import pagemap_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  word_t            wdata,
    output word_t            regs_o [NREGS]
);
    word_t mem [NREGS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREGS; i++)
                mem[i] <= (i < CPU_WINS) ? word_t'(i) : '0;
        end else if (we) begin
            mem[widx] <= wdata;
        end
    end

    always_comb begin
        for (int i = 0; i < NREGS; i++) regs_o[i] = mem[i];
    end
endmodule

// File: rtl/pagemap_xlate.sv
module pagemap_xlate
    import pagemap_pkg::*;
#(
    parameter int N     = 64,
    parameter int SEL_W = 6
) (
    input  word_t             tbl [N],
    input  logic [SEL_W-1:0]  sel,
    input  logic [OFS_W-1:0]  ofs,
    output logic [PA_W-1:0]   paddr
);
    word_t bank;
    always_comb begin
        bank  = tbl[sel];
        paddr = {bank[BANK_W-1:0], ofs};
    end
endmodule

// File: rtl/pagemap_warm.sv
module pagemap_warm
    import pagemap_pkg::*;
(
    input  word_t dma_tbl [DMA_REGS],
    output logic  warm
);
    logic [DMA_CHANS-1:0] ch_ok;
    for (genvar c = 0; c < DMA_CHANS; c++) begin : g_chan
        assign ch_ok[c] = (dma_tbl[c*DMA_QTRS + 2] == SIG_Q2) &&
                          (dma_tbl[c*DMA_QTRS + 3] == SIG_Q3);
    end
    assign warm = &ch_ok;
endmodule

// File: rtl/pagemap_top.sv
module pagemap_top
    import pagemap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [15:0]       io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [15:0]       io_wdata,
    output logic [15:0]       io_rdata,
    input  logic [19:0]       cpu_addr,
    output logic [23:0]       cpu_paddr,
    input  logic [1:0]        dma_chan,
    input  logic [15:0]       dma_addr,
    output logic [23:0]       dma_paddr,
    output logic              warm_boot
);
    regsel_t sel;
    word_t   regs    [NREGS];
    word_t   cpu_tbl [CPU_WINS];
    word_t   dma_tbl [DMA_REGS];

    assign sel = decode_port(io_addr);

    pagemap_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .we     (io_wr && sel.hit),
        .widx   (sel.idx),
        .wdata  (io_wdata),
        .regs_o (regs)
    );

    always_comb begin
        for (int i = 0; i < CPU_WINS; i++) cpu_tbl[i] = regs[i];
        for (int i = 0; i < DMA_REGS; i++) dma_tbl[i] = regs[CPU_WINS + i];
    end

    pagemap_xlate #(.N(CPU_WINS), .SEL_W(CPU_SEL_W)) u_cpu_xl (
        .tbl   (cpu_tbl),
        .sel   (cpu_addr[CPU_AW-1:OFS_W]),
        .ofs   (cpu_addr[OFS_W-1:0]),
        .paddr (cpu_paddr)
    );

    pagemap_xlate #(.N(DMA_REGS), .SEL_W(DMA_SEL_W)) u_dma_xl (
        .tbl   (dma_tbl),
        .sel   ({dma_chan, dma_addr[DMA_AW-1:OFS_W]}),
        .ofs   (dma_addr[OFS_W-1:0]),
        .paddr (dma_paddr)
    );

    pagemap_warm u_warm (
        .dma_tbl (dma_tbl),
        .warm    (warm_boot)
    );

    assign io_rdata = (io_rd && sel.hit) ? regs[sel.idx] : '0;
endmodule

// File: rtl/pagemap_chk.sv
module pagemap_chk (
    input logic        clk,
    input logic        rst,
    input logic [15:0] io_addr,
    input logic        io_wr,
    input logic        io_rd,
    input logic [15:0] io_wdata,
    input logic [15:0] io_rdata,
    input logic [19:0] cpu_addr,
    input logic [23:0] cpu_paddr,
    input logic [1:0]  dma_chan,
    input logic [15:0] dma_addr,
    input logic [23:0] dma_paddr,
    input logic        warm_boot
);
    AST_CPU_WRITE_NEXT: assert property (@(posedge clk) disable iff (rst)
        (io_wr && io_addr[15:7] == 9'd0) |=>
        ((cpu_addr[19:14] != $past(io_addr[6:1])) ||
         (cpu_paddr[23:14] == $past(io_wdata[9:0])))); // R4

    AST_DMA_WRITE_NEXT: assert property (@(posedge clk) disable iff (rst)
        (io_wr && io_addr[15:5] == 11'd4) |=>
        (({dma_chan, dma_addr[15:14]} != $past(io_addr[4:1])) ||
         (dma_paddr[23:14] == $past(io_wdata[9:0])))); // R3

    AST_CPU_WR_KEEPS_WARM: assert property (@(posedge clk) disable iff (rst)
        (io_wr && io_addr[15:7] == 9'd0) |=> $stable(warm_boot)); // R6

    AST_HIGH_PORT_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (io_wr && (io_addr[15:8] != 8'd0 || io_addr[7:5] > 3'd4)) |=>
        (!$stable(cpu_addr) || $stable(cpu_paddr))); // R7

    AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (rst)
        !io_rd |-> io_rdata == 16'd0); // R8
endmodule

bind pagemap_top pagemap_chk i_chk (.*);

// File: tb/test_pagemap_top.sv
`timescale 1ns/1ps
module test_pagemap_top;
    logic        clk = 0;
    logic        rst = 1;
    logic [15:0] io_addr = 0;
    logic        io_wr = 0;
    logic        io_rd = 0;
    logic [15:0] io_wdata = 0;
    logic [15:0] io_rdata;
    logic [19:0] cpu_addr = 0;
    logic [23:0] cpu_paddr;
    logic [1:0]  dma_chan = 0;
    logic [15:0] dma_addr = 0;
    logic [23:0] dma_paddr;
    logic        warm_boot;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    pagemap_top i_pagemap_top (.*);

    typedef struct packed {
        logic [15:0] port;
        logic [15:0] data;
        logic [19:0] probe;
        logic [23:0] expect_pa;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{16'h0000, 16'h0123, 20'h00ABC, 24'h48CABC},   // R2 window 0
        '{16'h007E, 16'h03FF, 20'hFFFFF, 24'hFFFFFF},   // R2 top window
        '{16'h0011, 16'hFC05, 20'h20010, 24'h014010},   // R5 R7 odd port, high bits
        '{16'h0040, 16'h0200, 20'h81234, 24'h801234},   // R2 window 32
        '{16'h00A0, 16'h0155, 20'h00004, 24'h48C004},   // R7 ignored port
        '{16'h0102, 16'h0077, 20'h04000, 24'h004000}    // R7 high address
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1;
        @(negedge clk);
        io_wr = 0;
    endtask

    task automatic rd_check(input string req, input logic [15:0] a, input logic [15:0] exp);
        @(negedge clk);
        io_addr = a; io_rd = 1;
        #1 check(req, 32'(io_rdata), 32'(exp));
        io_rd = 0;
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        cpu_addr = 20'h54321; dma_chan = 2; dma_addr = 16'h1234;
        #1;
        check("R1 cpu identity", 32'(cpu_paddr), 32'h054321);
        check("R1 dma zero", 32'(dma_paddr), 32'h001234);
        check("R1 warm low", 32'(warm_boot), 0);
        rd_check("R1 readback reg1", 16'h0002, 16'h0001);

        // vector table
        foreach (VECS[i]) begin
            wr(VECS[i].port, VECS[i].data);
            cpu_addr = VECS[i].probe;
            #1 check("R2/R7 vector", 32'(cpu_paddr), 32'(VECS[i].expect_pa));
        end

        // R5 full word read back
        rd_check("R5 readback upper bits", 16'h0010, 16'hFC05);
        // R8 out-of-range read and idle read
        rd_check("R8 read above range", 16'h00A0, 16'h0000);
        @(negedge clk);
        io_addr = 16'h0010; io_rd = 0;
        #1 check("R8 idle read zero", 32'(io_rdata), 0);

        // R4 same-cycle old value, then new value
        @(negedge clk);
        cpu_addr = 20'h0C000;
        io_addr = 16'h0006; io_wdata = 16'h0100; io_wr = 1;
        #1 check("R4 old value in write cycle", 32'(cpu_paddr), 32'h00C000);
        @(negedge clk);
        io_wr = 0;
        #1 check("R4 new value next cycle", 32'(cpu_paddr), 32'h400000);

        // R3 DMA translation, channel 1 quarter 3
        wr(16'h008E, 16'h0055);
        dma_chan = 1; dma_addr = 16'hC010;
        #1 check("R3 dma ch1 q3", 32'(dma_paddr), 32'h154010);
        dma_chan = 0; dma_addr = 16'hC010;
        #1 check("R3 dma ch0 q3 untouched", 32'(dma_paddr), 32'h000010);

        // R6 warm-boot signature
        for (int c = 0; c < 3; c++) begin
            wr(16'h0084 + 16'(8*c), 16'h00AD);
            wr(16'h0086 + 16'(8*c), 16'h00EC);
        end
        #1 check("R6 three channels only", 32'(warm_boot), 0);
        wr(16'h009C, 16'h00AD);
        wr(16'h009E, 16'h00EC);
        #1 check("R6 all channels", 32'(warm_boot), 1);
        wr(16'h0020, 16'h00AD);
        #1 check("R6 cpu write no effect", 32'(warm_boot), 1);
        wr(16'h0094, 16'h00AE);
        #1 check("R6 broken signature", 32'(warm_boot), 0);

        finish_run();
    end
endmodule